// File: doc/BRIEF.md
# Disk Seek Command Sequencer

This block turns a one-word seek command into the signal sequence that a moving-head disk drive expects on its positioning interface. Host logic offers a target cylinder on a valid/ready command port. The sequencer accepts it and drives the target onto the drive's cylinder lines. It waits a setup interval and then asserts the seek strobe for a fixed width. The drive takes the address on the falling edge of that strobe, so the address is kept unchanged across the strobe and for a hold interval after it.

After the strobe is released, the sequencer watches the drive's busy line and its address-interlock line through synchronizers. The busy line is captured by edge latches rather than sampled live, so a busy pulse that rises, or even rises and falls, before the sequencer starts waiting is still counted. The seek ends in exactly one of three ways, each reported as a one-clock pulse:
- completion, after busy has been seen to rise and then fall;
- an interlock error, when the drive refuses the target (valid targets are 0 to 405);
- a timeout, when neither event happens within a programmable number of clocks.

The command port follows the usual valid/ready rule. A command transfers on a clock edge where both `cmd_valid` and `cmd_ready` are high. `cmd_ready` is high only while the sequencer is idle, so the host holds off for the whole seek. Whatever the host drives while `cmd_ready` is low has no effect.

Top module: `seek_sequencer`

## Requirements
- R1: On the clock edge that accepts a command, `drv_cyl` takes the target. `drv_strobe` rises exactly SETUP_CLK clocks later, with SETUP_CLK at least 2.
- R2: `drv_strobe` stays high for exactly STROBE_CLK clocks. `drv_cyl` does not change while the strobe is high, nor for HOLD_CLK (at least 2) clocks after it falls.
- R3: Busy edges are latched from strobe assertion onward. A busy pulse that rises and falls before the hold interval ends still completes the seek with `done`.
- R4: Once busy has been seen high and then low, `done` pulses high for exactly one clock. This holds for full-stroke (0 to 405), half-range (203) and one-cylinder seeks.
- R5: A rise on `drv_interlock` seen after strobe assertion ends the seek with a one-clock `err_interlock` pulse and a return to idle. The next command is accepted without reset.
- R6: If the seek has not ended within TIMEOUT_CLK clocks after the strobe falls, `err_timeout` pulses for one clock and the block returns to idle.
- R7: `cmd_ready` is high only in idle. While it is low, `cmd_valid` and `cmd_cyl` are ignored: no extra strobe occurs and `drv_cyl` keeps the accepted target.
- R8: After reset, `cmd_ready` is 1 and `drv_strobe`, `drv_cyl`, `done`, `err_interlock` and `err_timeout` are all 0.
- R9: Each accepted command produces exactly one of `done`, `err_interlock` or `err_timeout`. That pulse appears in a cycle where `cmd_ready` is already high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Host offers a seek command |
| cmd_ready | output | 1 | Sequencer idle, command will be taken |
| cmd_cyl | input | CYL_W | Target cylinder of the offered command |
| done | output | 1 | One-clock pulse: seek completed |
| err_interlock | output | 1 | One-clock pulse: drive refused the target |
| err_timeout | output | 1 | One-clock pulse: drive never completed |
| drv_cyl | output | CYL_W | Cylinder address lines to the drive |
| drv_strobe | output | 1 | Seek strobe, taken by the drive on its falling edge |
| drv_busy | input | 1 | Drive busy, asynchronous |
| drv_interlock | input | 1 | Drive address-interlock, asynchronous |

## Verification
The bench drives a drive model that raises busy at the strobe's falling edge and drops it after a single clock. A sequencer that only samples busy while waiting would miss that pulse and end in a timeout instead of `done`.

Targets of 406 and 511 must yield an interlock error, and a legal seek issued right after must succeed. A design that latched the error state would hang on that follow-up seek.

The bench measures the setup and strobe widths and watches the address across the strobe. An address that moved before release would hand the drive a wrong cylinder.

It also waves a second command during a long seek. A port that did not hold off would issue a second strobe or change the address.

// File: rtl/seek_pkg.sv
package seek_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_SETUP  = 3'd1,
    ST_STROBE = 3'd2,
    ST_HOLD   = 3'd3,
    ST_WAIT   = 3'd4
  } seek_state_e;

  typedef enum logic [1:0] {
    END_NONE      = 2'd0,
    END_DONE      = 2'd1,
    END_INTERLOCK = 2'd2,
    END_TIMEOUT   = 2'd3
  } seek_end_e;

endpackage

// File: rtl/seek_edge_latch.sv
// Synchronizes an asynchronous drive line and remembers that it rose,
// and that it later fell, until cleared.
module seek_edge_latch #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic din,
  output logic level,
  output logic rose_seen,
  output logic fell_seen
);

  logic [STAGES-1:0] sync_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], din};
      end
    end
  endgenerate

  assign level = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      rose_seen <= 1'b0;
      fell_seen <= 1'b0;
    end else begin
      if (level) rose_seen <= 1'b1;
      if (rose_seen && !level) fell_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/seek_countdown.sv
// Loadable down counter; zero is high when the count has run out.
module seek_countdown #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load)                cnt_q <= load_val;
    else if (en && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/seek_sequencer.sv
module seek_sequencer #(
  parameter int CYL_W       = 9,
  parameter int SETUP_CLK   = 2,
  parameter int STROBE_CLK  = 4,
  parameter int HOLD_CLK    = 2,
  parameter int TIMEOUT_CLK = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [CYL_W-1:0] cmd_cyl,
  output logic             done,
  output logic             err_interlock,
  output logic             err_timeout,
  output logic [CYL_W-1:0] drv_cyl,
  output logic             drv_strobe,
  input  logic             drv_busy,
  input  logic             drv_interlock
);
  import seek_pkg::*;

  localparam int PH_MAX = (SETUP_CLK > STROBE_CLK) ?
                          ((SETUP_CLK > HOLD_CLK) ? SETUP_CLK : HOLD_CLK) :
                          ((STROBE_CLK > HOLD_CLK) ? STROBE_CLK : HOLD_CLK);
  localparam int PH_W = $clog2(PH_MAX + 1);
  localparam int TO_W = $clog2(TIMEOUT_CLK + 1);
  localparam logic [PH_W-1:0] SETUP_LD  = PH_W'(SETUP_CLK - 1);
  localparam logic [PH_W-1:0] STROBE_LD = PH_W'(STROBE_CLK - 1);
  localparam logic [PH_W-1:0] HOLD_LD   = PH_W'(HOLD_CLK - 1);
  localparam logic [TO_W-1:0] TO_LD     = TO_W'(TIMEOUT_CLK - 1);

  seek_state_e      state_q, state_d;
  seek_end_e        end_d;
  logic [CYL_W-1:0] cyl_q;
  logic             accept;
  logic             ph_load, ph_zero, ph_en;
  logic [PH_W-1:0]  ph_val;
  logic             to_load, to_zero, to_en;
  logic             latch_clr;
  logic             busy_lvl, busy_rose, busy_fell;
  logic             il_lvl, il_rose, il_fell;
  logic             done_q, il_q, to_q;

  assign cmd_ready = (state_q == ST_IDLE);
  assign accept    = cmd_valid && cmd_ready;
  assign latch_clr = (state_q == ST_IDLE) || (state_q == ST_SETUP);

  seek_edge_latch #(.STAGES(SYNC_STAGES)) u_busy (
    .clk(clk), .rst_n(rst_n), .clr(latch_clr), .din(drv_busy),
    .level(busy_lvl), .rose_seen(busy_rose), .fell_seen(busy_fell)
  );

  seek_edge_latch #(.STAGES(SYNC_STAGES)) u_ilock (
    .clk(clk), .rst_n(rst_n), .clr(latch_clr), .din(drv_interlock),
    .level(il_lvl), .rose_seen(il_rose), .fell_seen(il_fell)
  );

  seek_countdown #(.W(PH_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val),
    .en(ph_en), .zero(ph_zero)
  );

  seek_countdown #(.W(TO_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .load(to_load), .load_val(TO_LD),
    .en(to_en), .zero(to_zero)
  );

  always_comb begin
    state_d = state_q;
    end_d   = END_NONE;
    ph_load = 1'b0;
    ph_val  = SETUP_LD;
    to_load = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          state_d = ST_SETUP;
          ph_load = 1'b1;
          ph_val  = SETUP_LD;
        end
      end
      ST_SETUP: begin
        if (ph_zero) begin
          state_d = ST_STROBE;
          ph_load = 1'b1;
          ph_val  = STROBE_LD;
        end
      end
      ST_STROBE: begin
        if (ph_zero) begin
          state_d = ST_HOLD;
          ph_load = 1'b1;
          ph_val  = HOLD_LD;
          to_load = 1'b1;
        end
      end
      ST_HOLD: begin
        if (il_rose) begin
          state_d = ST_IDLE;
          end_d   = END_INTERLOCK;
        end else if (ph_zero) begin
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (il_rose) begin
          state_d = ST_IDLE;
          end_d   = END_INTERLOCK;
        end else if (busy_fell) begin
          state_d = ST_IDLE;
          end_d   = END_DONE;
        end else if (to_zero) begin
          state_d = ST_IDLE;
          end_d   = END_TIMEOUT;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ph_en = (state_q == ST_SETUP) || (state_q == ST_STROBE) ||
                 (state_q == ST_HOLD);
  assign to_en = (state_q == ST_HOLD) || (state_q == ST_WAIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cyl_q   <= '0;
      done_q  <= 1'b0;
      il_q    <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) cyl_q <= cmd_cyl;
      done_q  <= (end_d == END_DONE);
      il_q    <= (end_d == END_INTERLOCK);
      to_q    <= (end_d == END_TIMEOUT);
    end
  end

  assign drv_cyl       = cyl_q;
  assign drv_strobe    = (state_q == ST_STROBE);
  assign done          = done_q;
  assign err_interlock = il_q;
  assign err_timeout   = to_q;

endmodule

// File: rtl/seek_sequencer_chk.sv
module seek_sequencer_chk #(
  parameter int CYL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             done,
  input logic             err_interlock,
  input logic             err_timeout,
  input logic [CYL_W-1:0] drv_cyl,
  input logic             drv_strobe
);

  assert_strobe_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_strobe) |-> !cmd_ready);

  assert_addr_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_strobe || $past(drv_strobe)) |-> $stable(drv_cyl));

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_ilock_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_interlock |=> !err_interlock);

  assert_tmo_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> !err_timeout);

  assert_accept_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_hold_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_ready |=> $stable(drv_cyl));

  assert_one_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err_interlock, err_timeout}));

  assert_end_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_interlock || err_timeout) |-> cmd_ready);

endmodule

bind seek_sequencer seek_sequencer_chk #(.CYL_W(CYL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .done(done), .err_interlock(err_interlock), .err_timeout(err_timeout),
  .drv_cyl(drv_cyl), .drv_strobe(drv_strobe)
);

// File: tb/tb_seek_sequencer.sv
module tb_seek_sequencer;

  localparam int CYL_W  = 9;
  localparam int SETUP  = 3;
  localparam int STROBE = 4;
  localparam int HOLD   = 2;
  localparam int TMO    = 300;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [CYL_W-1:0] cmd_cyl = '0;
  logic cmd_ready, done, err_interlock, err_timeout, drv_strobe;
  logic [CYL_W-1:0] drv_cyl;
  logic drv_busy = 1'b0;
  logic drv_interlock = 1'b0;

  always #10 clk = ~clk;

  seek_sequencer #(.CYL_W(CYL_W), .SETUP_CLK(SETUP), .STROBE_CLK(STROBE),
                   .HOLD_CLK(HOLD), .TIMEOUT_CLK(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_cyl(cmd_cyl), .done(done), .err_interlock(err_interlock),
    .err_timeout(err_timeout), .drv_cyl(drv_cyl), .drv_strobe(drv_strobe),
    .drv_busy(drv_busy), .drv_interlock(drv_interlock)
  );

  int tests = 0;
  int fails = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive model: acts on the strobe's falling edge.
  int m_rise = 0;
  int m_len  = 0;
  int cap_cyl = -1;
  int strobe_rises = 0;
  logic strobe_d = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      if (!strobe_d && drv_strobe) strobe_rises++;
      if (strobe_d && !drv_strobe) begin
        cap_cyl = int'(drv_cyl);
        strobe_d = 1'b0;
        if (cap_cyl > 405) begin
          repeat (2) @(negedge clk);
          drv_interlock = 1'b1;
          repeat (5) @(negedge clk);
          drv_interlock = 1'b0;
        end else if (m_len != 0) begin
          repeat (m_rise) @(negedge clk);
          drv_busy = 1'b1;
          repeat (m_len) @(negedge clk);
          drv_busy = 1'b0;
        end
      end
      strobe_d = drv_strobe;
    end
  end

  typedef struct packed {
    logic [8:0] cyl;
    logic [7:0] rise;
    logic [7:0] len;
    logic [1:0] outcome; // 0 done, 1 interlock, 2 timeout
  } vec_t;

  localparam vec_t VEC [10] = '{
    '{9'd405, 8'd3, 8'd120, 2'd0},
    '{9'd0,   8'd3, 8'd120, 2'd0},
    '{9'd203, 8'd2, 8'd60,  2'd0},
    '{9'd0,   8'd2, 8'd60,  2'd0},
    '{9'd1,   8'd1, 8'd4,   2'd0},
    '{9'd2,   8'd0, 8'd1,   2'd0},
    '{9'd406, 8'd0, 8'd0,   2'd1},
    '{9'd511, 8'd0, 8'd0,   2'd1},
    '{9'd7,   8'd1, 8'd5,   2'd0},
    '{9'd100, 8'd0, 8'd0,   2'd2}
  };

  int n_setup, n_strobe, n_done, n_il, n_to, addr_moves, rises0;
  bit finished;

  // Issues one command and watches it to the end; optionally waves a
  // second command while the seek is in progress.
  task automatic run_seek(input int cyl, input int rise, input int len,
                          input bit wave_other);
    bit seen;
    int cyc;
    n_setup = 0; n_strobe = 0; n_done = 0; n_il = 0; n_to = 0;
    addr_moves = 0; finished = 1'b0; seen = 1'b0; cyc = 0;
    m_rise = rise; m_len = len;
    rises0 = strobe_rises;
    @(negedge clk);
    cmd_cyl = CYL_W'(cyl);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!finished && cyc < 2000) begin
      cyc++;
      if (wave_other) begin
        if (cyc == 10) begin cmd_valid = 1'b1; cmd_cyl = 9'd77; end
        if (cyc == 30) cmd_valid = 1'b0;
      end
      if (drv_strobe) begin n_strobe++; seen = 1'b1; end
      else if (!seen && !cmd_ready) n_setup++;
      if (int'(drv_cyl) != cyl) addr_moves++;
      if (done) n_done++;
      if (err_interlock) n_il++;
      if (err_timeout) n_to++;
      if (cmd_ready && seen) finished = 1'b1;
      @(negedge clk);
    end
    repeat (3) begin
      if (done) n_done++;
      if (err_interlock) n_il++;
      if (err_timeout) n_to++;
      @(negedge clk);
    end
    repeat (8) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    check(cmd_ready === 1'b1, "R8", "ready in reset", int'(cmd_ready), 1);
    check(drv_strobe === 1'b0 && drv_cyl === '0, "R8", "strobe/addr in reset",
          int'(drv_cyl), 0);
    check({done, err_interlock, err_timeout} === 3'b000, "R8", "ends in reset",
          int'({done, err_interlock, err_timeout}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cmd_ready === 1'b1 && drv_strobe === 1'b0, "R8", "idle after reset",
          int'(cmd_ready), 1);

    foreach (VEC[i]) begin
      vec_t v;
      v = VEC[i];
      run_seek(int'(v.cyl), int'(v.rise), int'(v.len), 1'b0);
      check(finished, "R9", "seek ended", int'(finished), 1);
      check(n_setup == SETUP, "R1", "setup clocks", n_setup, SETUP);
      check(n_strobe == STROBE, "R2", "strobe width", n_strobe, STROBE);
      check(addr_moves == 0, "R2", "address held", addr_moves, 0);
      check(cap_cyl == int'(v.cyl), "R2", "drive captured", cap_cyl, int'(v.cyl));
      case (v.outcome)
        2'd0: begin
          if (v.len == 8'd1)
            check(n_done == 1 && n_to == 0, "R3", "early busy pulse -> done",
                  n_done, 1);
          check(n_done == 1 && n_il == 0 && n_to == 0, "R4", "single done",
                n_done, 1);
          if (i == 8)
            check(n_done == 1, "R5", "recovery after interlock", n_done, 1);
        end
        2'd1: check(n_il == 1 && n_done == 0 && n_to == 0, "R5",
                    "single interlock error", n_il, 1);
        default: check(n_to == 1 && n_done == 0 && n_il == 0, "R6",
                       "single timeout", n_to, 1);
      endcase
      check(n_done + n_il + n_to == 1, "R9", "exactly one ending",
            n_done + n_il + n_to, 1);
    end

    // R7: second command offered during a long seek is ignored.
    run_seek(300, 2, 150, 1'b1);
    check(strobe_rises - rises0 == 1, "R7", "strobes during hold-off",
          strobe_rises - rises0, 1);
    check(addr_moves == 0 && drv_cyl == 9'd300, "R7", "address during hold-off",
          int'(drv_cyl), 300);
    check(n_done == 1, "R7", "first seek still completes", n_done, 1);

    // R5: back-to-back interlock errors, then a good seek without reset.
    run_seek(450, 0, 0, 1'b0);
    check(n_il == 1, "R5", "interlock again", n_il, 1);
    run_seek(405, 1, 30, 1'b0);
    check(n_done == 1 && cap_cyl == 405, "R5", "good seek after errors",
          n_done, 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule